// File: doc/BRIEF.md
# Fractional Saturating Multiply-Accumulate Unit

This block is a multiply-accumulate datapath built around one 40-bit accumulator: 32 result bits plus 8 guard bits. Each accepted command multiplies two 16-bit operands. The product can then be written into the accumulator, added to it, or subtracted from it. Operand signedness is selectable: both signed, first signed and second unsigned, or both unsigned.

Two control bits shape the arithmetic. The fractional bit doubles the product, which suits Q15 × Q15 data. The saturation bit enables clamping. Saturation applies only to signed × signed commands. It has two stages:

- The doubled product of −1 × −1 is held at the largest positive 32-bit value.
- The accumulated result is limited to the signed 32-bit range.

Commands in the other signedness modes wrap modulo 2^40. A sticky flag records that a clamp has occurred. The accumulator is registered and is presented directly on the output. Register files and instruction decode belong to the surrounding core.

Top module: `frac_mac`

## Requirements
- R1: While rst_ni is low, acc_o is 0 and sat_flag_o is 0.
- R2: op_i encodes 0 = load product, 1 = add product, 2 = subtract product, 3 = no operation. mode_i encodes 0 = signed×signed, 1 = a_i signed × b_i unsigned, 2 and 3 = unsigned×unsigned. A load in mode 0 with frac_i and sat_i low writes the signed product, sign-extended to 40 bits, one clock after valid_i.
- R3: With frac_i high, the product is shifted left by one bit and truncated to 40 bits before it is used.
- R4: In mode 0 with sat_i high, a scaled product greater than 0x7FFF_FFFF is replaced by 0x7FFF_FFFF. Without doubling, no product reaches this bound.
- R5: op_i = 1 writes the sign-extended accumulator plus the scaled product.
- R6: op_i = 2 writes the sign-extended accumulator minus the scaled product.
- R7: In mode 0 with sat_i high, the written result is clamped to the range 0xFF_8000_0000 to 0x00_7FFF_FFFF.
- R8: When sat_i is low, or the mode is not 0, the result is truncated to 40 bits and wraps.
- R9: Modes 1, 2 and 3 never clamp, whatever sat_i is. Mode 1 treats b_i as unsigned. Modes 2 and 3 treat both operands as unsigned.
- R10: The accumulator holds its value when valid_i is low, and when op_i = 3.
- R11: sat_flag_o goes high one clock after any accepted command that applies a clamp. It stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Command strobe |
| op_i | input | 2 | Operation: load, add, subtract, none |
| mode_i | input | 2 | Operand signedness mode |
| frac_i | input | 1 | Fractional doubling enable |
| sat_i | input | 1 | Saturation enable |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| acc_o | output | 40 | Registered accumulator |
| sat_flag_o | output | 1 | Sticky clamp indicator |

## Verification
The same operand pair 0x8000 × 0x8000 is applied in all three signedness modes, with and without doubling. This shows whether each mode's sign handling is right, and whether the −1 × −1 product clamp fires only in the signed, saturating case. Repeated additions and subtractions of near-full-scale products drive the accumulator past both 32-bit bounds. With saturation on, this shows the clamp and the flag; with saturation off, it shows that the guard bits take the carry with no clamp. A run of 130 unsigned doubled additions wraps the full 40-bit register, which exposes any width or truncation error. Idle cycles and no-operation commands with live operands confirm that the register holds.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2,
    OP_NONE = 2'd3
  } mac_op_e;

  typedef enum logic [1:0] {
    MD_SS  = 2'd0,
    MD_SU  = 2'd1,
    MD_UU  = 2'd2,
    MD_UU3 = 2'd3
  } mac_mode_e;
endpackage

// File: rtl/frac_mac_product.sv
module frac_mac_product
  import frac_mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  input  mac_mode_e        mode_i,
  input  logic             frac_i,
  input  logic             sat_i,
  output logic [ACC_W-1:0] prod_o,
  output logic             clamp_o
);
  localparam int PX_W  = OP_W + 1;
  localparam int PR_W  = 2 * PX_W;
  localparam int RES_W = 2 * OP_W;
  localparam logic [ACC_W-1:0] PMAX = {{(ACC_W-RES_W+1){1'b0}}, {(RES_W-1){1'b1}}};

  logic signed [PX_W-1:0]  ax, bx;
  logic signed [PR_W-1:0]  raw;
  logic        [ACC_W-1:0] ext, scaled;
  logic                    a_sgn, b_sgn;

  always_comb begin
    a_sgn = (mode_i == MD_SS) || (mode_i == MD_SU);
    b_sgn = (mode_i == MD_SS);
    ax    = {a_sgn & a_i[OP_W-1], a_i};
    bx    = {b_sgn & b_i[OP_W-1], b_i};
    raw   = ax * bx;
  end

  // widen the product to the accumulator width
  generate
    if (ACC_W > PR_W) begin : g_ext
      assign ext = {{(ACC_W-PR_W){raw[PR_W-1]}}, raw};
    end else begin : g_trunc
      assign ext = raw[ACC_W-1:0];
    end
  endgenerate

  always_comb begin
    scaled  = frac_i ? {ext[ACC_W-2:0], 1'b0} : ext;
    clamp_o = sat_i && (mode_i == MD_SS) && ($signed(scaled) > $signed(PMAX));
    prod_o  = clamp_o ? PMAX : scaled;
  end
endmodule

// File: rtl/frac_mac_accum.sv
module frac_mac_accum
  import frac_mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [ACC_W-1:0] prod_i,
  input  mac_op_e          op_i,
  input  logic             sat_en_i,
  output logic [ACC_W-1:0] nxt_o,
  output logic             clamp_o
);
  localparam int SUM_W = ACC_W + 2;
  localparam int RES_W = 2 * OP_W;
  localparam logic [SUM_W-1:0] RMAX = {{(SUM_W-RES_W+1){1'b0}}, {(RES_W-1){1'b1}}};
  localparam logic [SUM_W-1:0] RMIN = {{(SUM_W-RES_W+1){1'b1}}, {(RES_W-1){1'b0}}};

  logic signed [SUM_W-1:0] acc_x, prod_x, sum;
  logic                    over_hi, over_lo;

  always_comb begin
    acc_x  = {{2{acc_i[ACC_W-1]}}, acc_i};
    prod_x = {{2{prod_i[ACC_W-1]}}, prod_i};
    unique case (op_i)
      OP_ADD:  sum = acc_x + prod_x;
      OP_SUB:  sum = acc_x - prod_x;
      OP_LOAD: sum = prod_x;
      default: sum = acc_x;
    endcase
    over_hi = sum > $signed(RMAX);
    over_lo = sum < $signed(RMIN);
    clamp_o = sat_en_i && (over_hi || over_lo);
    if (sat_en_i && over_hi)      nxt_o = RMAX[ACC_W-1:0];
    else if (sat_en_i && over_lo) nxt_o = RMIN[ACC_W-1:0];
    else                          nxt_o = sum[ACC_W-1:0];
  end
endmodule

// File: rtl/frac_mac.sv
module frac_mac
  import frac_mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int GRD_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [1:0]              op_i,
  input  logic [1:0]              mode_i,
  input  logic                    frac_i,
  input  logic                    sat_i,
  input  logic [OP_W-1:0]         a_i,
  input  logic [OP_W-1:0]         b_i,
  output logic [2*OP_W+GRD_W-1:0] acc_o,
  output logic                    sat_flag_o
);
  localparam int ACC_W = 2 * OP_W + GRD_W;
  localparam int RES_W = 2 * OP_W;
  localparam logic [ACC_W-1:0] A_MAX = {{(GRD_W+1){1'b0}}, {(RES_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] A_MIN = {{(GRD_W+1){1'b1}}, {(RES_W-1){1'b0}}};

  mac_op_e          op;
  mac_mode_e        mode;
  logic [ACC_W-1:0] acc_q, prod, nxt;
  logic             flag_q, p_clamp, r_clamp, take;

  assign op   = mac_op_e'(op_i);
  assign mode = mac_mode_e'(mode_i);
  assign take = valid_i && (op != OP_NONE);

  frac_mac_product #(.OP_W(OP_W), .ACC_W(ACC_W)) u_prod (
    .a_i    (a_i),
    .b_i    (b_i),
    .mode_i (mode),
    .frac_i (frac_i),
    .sat_i  (sat_i),
    .prod_o (prod),
    .clamp_o(p_clamp)
  );

  frac_mac_accum #(.OP_W(OP_W), .ACC_W(ACC_W)) u_acc (
    .acc_i   (acc_q),
    .prod_i  (prod),
    .op_i    (op),
    .sat_en_i(sat_i && (mode == MD_SS)),
    .nxt_o   (nxt),
    .clamp_o (r_clamp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      flag_q <= 1'b0;
    end else if (take) begin
      acc_q  <= nxt;
      flag_q <= flag_q | p_clamp | r_clamp;
    end
  end

  assign acc_o      = acc_q;
  assign sat_flag_o = flag_q;

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && op_i != 2'd3) |=> $stable(acc_o)); // R10
  AST_SAT_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i != 2'd3 && mode_i == 2'd0 && sat_i) |=>
      ($signed(acc_o) <= $signed(A_MAX) && $signed(acc_o) >= $signed(A_MIN))); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_flag_o |=> sat_flag_o); // R11
  AST_NO_CLAMP_UNSIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'd0 && !sat_flag_o) |=> !sat_flag_o); // R9
  AST_UNSCALED_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'd0 && !frac_i && !sat_flag_o) |=> !sat_flag_o); // R4
endmodule

// File: tb/frac_mac_test.sv
module frac_mac_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = 2'd0;
  logic [1:0]  mode_i = 2'd0;
  logic        frac_i = 1'b0;
  logic        sat_i = 1'b0;
  logic [15:0] a_i = '0;
  logic [15:0] b_i = '0;
  logic [39:0] acc_o;
  logic        sat_flag_o;

  int     n_vec = 0;
  int     n_bad = 0;
  longint exp_acc = 0;
  logic   exp_flag = 1'b0;
  logic   done = 1'b0;

  localparam longint M40  = 64'h00FF_FFFF_FFFF;
  localparam longint MAX32 = 64'h0000_7FFF_FFFF;
  localparam longint MIN32 = -64'sh0000_8000_0000;

  always #2 clk_i = ~clk_i;

  frac_mac uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .mode_i(mode_i), .frac_i(frac_i), .sat_i(sat_i), .a_i(a_i), .b_i(b_i),
    .acc_o(acc_o), .sat_flag_o(sat_flag_o)
  );

  function automatic longint sx40(longint v);
    return v[39] ? (v | ~M40) : (v & M40);
  endfunction

  function automatic longint ref_step(longint acc, logic [1:0] op, logic [1:0] md,
                                      logic fr, logic st, logic [15:0] a, logic [15:0] b,
                                      output logic clamp);
    longint pa, pb, p, r;
    clamp = 1'b0;
    if (op == 2'd3) return acc;
    pa = (md <= 2'd1) ? longint'($signed(a)) : longint'({48'b0, a});
    pb = (md == 2'd0) ? longint'($signed(b)) : longint'({48'b0, b});
    p = pa * pb;
    if (fr) p = p <<< 1;
    p = sx40(p);
    if (md == 2'd0 && st && p > MAX32) begin p = MAX32; clamp = 1'b1; end
    case (op)
      2'd0:    r = p;
      2'd1:    r = sx40(acc) + p;
      default: r = sx40(acc) - p;
    endcase
    if (md == 2'd0 && st) begin
      if (r > MAX32) begin r = MAX32; clamp = 1'b1; end
      else if (r < MIN32) begin r = MIN32; clamp = 1'b1; end
    end
    return r & M40;
  endfunction

  task automatic check(string req);
    n_vec++;
    if (acc_o !== exp_acc[39:0] || sat_flag_o !== exp_flag) begin
      n_bad++;
      $display("FAIL %s: acc=%h flag=%b expected acc=%h flag=%b",
               req, acc_o, sat_flag_o, exp_acc[39:0], exp_flag);
    end
  endtask

  task automatic drive(logic [1:0] op, logic [1:0] md, logic fr, logic st,
                       logic [15:0] a, logic [15:0] b, string req);
    logic cl;
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; mode_i = md; frac_i = fr; sat_i = st; a_i = a; b_i = b;
    exp_acc = ref_step(exp_acc, op, md, fr, st, a, b, cl);
    exp_flag = exp_flag | cl;
    @(negedge clk_i);
    valid_i = 1'b0;
    check(req);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    exp_acc = 0; exp_flag = 1'b0;
    @(negedge clk_i);
    check("R1");
    rst_ni = 1'b1;
  endtask

  task automatic t_load_ss;
    drive(2'd0, 2'd0, 1'b0, 1'b0, 16'd3, 16'd5, "R2");
    drive(2'd0, 2'd0, 1'b0, 1'b0, 16'hFFFD, 16'd7, "R2");
    drive(2'd0, 2'd0, 1'b0, 1'b0, 16'h8000, 16'h8000, "R2");
    drive(2'd0, 2'd0, 1'b0, 1'b1, 16'h8000, 16'h7FFF, "R2");
  endtask

  task automatic t_frac;
    drive(2'd0, 2'd0, 1'b1, 1'b0, 16'h4000, 16'h4000, "R3");
    drive(2'd0, 2'd0, 1'b1, 1'b0, 16'h8000, 16'h8000, "R3");
    drive(2'd0, 2'd0, 1'b1, 1'b0, 16'hC000, 16'h4000, "R3");
  endtask

  task automatic t_prod_clamp;
    drive(2'd0, 2'd0, 1'b1, 1'b1, 16'h8000, 16'h8000, "R4");
    drive(2'd0, 2'd0, 1'b1, 1'b1, 16'h7FFF, 16'h7FFF, "R11");
  endtask

  task automatic t_add_sub;
    drive(2'd0, 2'd0, 1'b0, 1'b0, 16'd100, 16'd200, "R2");
    drive(2'd1, 2'd0, 1'b0, 1'b0, 16'hFFF6, 16'd30, "R5");
    drive(2'd1, 2'd0, 1'b1, 1'b0, 16'h1234, 16'h0567, "R5");
    drive(2'd2, 2'd0, 1'b0, 1'b0, 16'd1000, 16'd1000, "R6");
    drive(2'd2, 2'd0, 1'b1, 1'b1, 16'h8000, 16'd3, "R6");
  endtask

  task automatic t_sat;
    drive(2'd0, 2'd0, 1'b1, 1'b1, 16'h7FFF, 16'h7FFF, "R2");
    drive(2'd1, 2'd0, 1'b1, 1'b1, 16'h7FFF, 16'h7FFF, "R7");
    drive(2'd1, 2'd0, 1'b1, 1'b1, 16'h7FFF, 16'h7FFF, "R7");
    drive(2'd0, 2'd0, 1'b1, 1'b1, 16'h8000, 16'h7FFF, "R2");
    drive(2'd2, 2'd0, 1'b1, 1'b1, 16'h7FFF, 16'h7FFF, "R7");
    drive(2'd1, 2'd0, 1'b0, 1'b1, 16'h0001, 16'h0001, "R11");
  endtask

  task automatic t_wrap;
    drive(2'd0, 2'd0, 1'b1, 1'b0, 16'h7FFF, 16'h7FFF, "R8");
    for (int i = 0; i < 4; i++) drive(2'd1, 2'd0, 1'b1, 1'b0, 16'h7FFF, 16'h7FFF, "R8");
    drive(2'd0, 2'd2, 1'b1, 1'b0, 16'hFFFF, 16'hFFFF, "R8");
    for (int i = 0; i < 130; i++) drive(2'd1, 2'd2, 1'b1, 1'b0, 16'hFFFF, 16'hFFFF, "R8");
  endtask

  task automatic t_unsigned_modes;
    drive(2'd0, 2'd1, 1'b1, 1'b1, 16'h8000, 16'h8000, "R9");
    drive(2'd0, 2'd2, 1'b1, 1'b1, 16'h8000, 16'h8000, "R9");
    drive(2'd0, 2'd3, 1'b0, 1'b1, 16'hFFFF, 16'h0002, "R9");
    drive(2'd0, 2'd1, 1'b0, 1'b1, 16'hFFFF, 16'hFFFF, "R9");
    for (int i = 0; i < 3; i++) drive(2'd1, 2'd2, 1'b1, 1'b1, 16'hFFFF, 16'hFFFF, "R9");
    drive(2'd2, 2'd1, 1'b1, 1'b1, 16'h7FFF, 16'hFFFF, "R9");
  endtask

  task automatic t_hold;
    drive(2'd0, 2'd0, 1'b0, 1'b0, 16'd77, 16'd9, "R2");
    @(negedge clk_i);
    valid_i = 1'b0; op_i = 2'd1; mode_i = 2'd0; frac_i = 1'b1; sat_i = 1'b1;
    a_i = 16'h8000; b_i = 16'h8000;
    @(negedge clk_i);
    check("R10");
    drive(2'd3, 2'd0, 1'b1, 1'b1, 16'h8000, 16'h8000, "R10");
  endtask

  initial begin
    t_reset();
    t_load_ss();
    t_frac();
    t_hold();
    t_unsigned_modes();
    t_add_sub();
    t_wrap();
    t_prod_clamp();
    t_reset();
    t_sat();
    t_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: acc=%h flag=%b expected run to complete", acc_o, sat_flag_o);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule